// File: doc/BRIEF.md
# Registered Rounding Parallel Multiplier

This block multiplies two operands of `W` bits (8 by default) and returns a product of twice that width. It is meant to sit on a microprocessor bus. Operand A and operand B each have their own holding register with its own load strobe. A round request is captured alongside the operands. A result register, loaded by a third strobe, holds the formatted product. The two halves of the result drive separate three-state byte lanes. Each lane has its own active-low enable. For each lane, a plain valid/data view is also brought out, so the result can be observed without a shared bus.

The parameter `SIGNED_MODE` selects the variant at compile time. In the signed variant, operands and result are two's complement. The sign is copied into the top bit of both result bytes, so the pair can serve as a double-precision operand. The single overflowing case, the most negative value squared, saturates. In the unsigned variant, operands and result are plain magnitudes. In both variants, setting the round bit adds one half of the lower byte's weight. Dropping the lower byte then leaves a correctly rounded single-precision product.

All three strobes are synchronous to one clock. The multiply runs combinationally from the operand registers into the result register within a single clock period.

Top module: `rnd_mult8`

## Requirements
- R1: `load_a` and `load_b` each load only their own operand register on a clock edge. An operand register whose strobe is low keeps its value.
- R2: When `load_r` is high on an edge, the result register takes the formatted product of the operand registers and round bit as they were before that edge, so it is visible in the next cycle. When `load_r` is low, both result bytes hold.
- R3: Unsigned variant: the result is S = A*B + (round ? 128 : 0). The high byte is S[15:8] and the low byte is S[7:0].
- R4: Signed variant: S = A*B + (round ? 64 : 0), taken as a signed value. The high byte is S[14:7] and the low byte is {S[15], S[6:0]}, so bit 7 of both bytes equals the sign.
- R5: Signed variant: -128 x -128 gives 0x7F in the high byte and 0x7F in the low byte, whether or not the round bit is set.
- R6: In the signed variant, the round bit is captured from `round_in` on any edge where `load_a` or `load_b` is high. In the unsigned variant, it is captured only on edges where `load_a` is high.
- R7: `oe_hi_n` and `oe_lo_n` are active low and each gates only its own byte. An enabled lane drives its result byte, and a disabled lane is high impedance. `hi_valid` and `lo_valid` are the inverted enables, and `hi_data` and `lo_data` always show the result bytes.
- R8: While `rst_n` is low, both operand registers, the round bit and the result register are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_a | input | 1 | Load strobe for operand A |
| load_b | input | 1 | Load strobe for operand B |
| load_r | input | 1 | Load strobe for the result register |
| round_in | input | 1 | Round request, captured per R6 |
| a_in | input | W | Operand A |
| b_in | input | W | Operand B |
| oe_hi_n | input | 1 | High byte output enable, active low |
| oe_lo_n | input | 1 | Low byte output enable, active low |
| prod_hi | output | W | Three-state high result byte |
| prod_lo | output | W | Three-state low result byte |
| hi_valid | output | 1 | High lane is enabled |
| lo_valid | output | 1 | Low lane is enabled |
| hi_data | output | W | High result byte, always driven |
| lo_data | output | W | Low result byte, always driven |

## Verification
The bench sweeps every operand pair with rounding both off and on, in both variants. This exposes a round constant at the wrong weight, which would shift about half of all rounded results by one code, and a sign bit left out of the low byte. The squared most negative value is driven directly, because a design that does not saturate it returns 0x80 in the high byte with a positive low byte. A round request sent with only the B strobe separates the variants: if the unsigned variant captures it, or the signed variant misses it, a rounded result comes out one step off. Random strobes also check that a result loaded in the same cycle as a new operand uses the old operand, and that each lane enable is independent of the other.

// File: rtl/rnd_mult8.sv
module rnd_mult8 #(
  parameter int W           = 8,
  parameter bit SIGNED_MODE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_a,
  input  logic         load_b,
  input  logic         load_r,
  input  logic         round_in,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         oe_hi_n,
  input  logic         oe_lo_n,
  output logic [W-1:0] prod_hi,
  output logic [W-1:0] prod_lo,
  output logic         hi_valid,
  output logic         lo_valid,
  output logic [W-1:0] hi_data,
  output logic [W-1:0] lo_data
);
  localparam int PW = 2 * W;
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] SAT_BYTE = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0]  a_q, b_q;
  logic          rnd_q;
  logic [PW-1:0] res_q, res_d;
  logic          rnd_load;

  assign rnd_load = SIGNED_MODE ? (load_a | load_b) : load_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      rnd_q <= 1'b0;
      res_q <= '0;
    end else begin
      if (load_a)   a_q   <= a_in;
      if (load_b)   b_q   <= b_in;
      if (rnd_load) rnd_q <= round_in;
      if (load_r)   res_q <= res_d;
    end
  end

  generate
    if (SIGNED_MODE) begin : g_signed
      logic signed [PW:0] a_x, b_x, rnd_x, sum;
      logic               ovf;
      assign a_x   = {{(W+1){a_q[W-1]}}, a_q};
      assign b_x   = {{(W+1){b_q[W-1]}}, b_q};
      assign rnd_x = {{(W+2){1'b0}}, rnd_q, {(W-2){1'b0}}};
      assign sum   = a_x * b_x + rnd_x;
      assign ovf   = (a_q == MOST_NEG) && (b_q == MOST_NEG);
      assign res_d = ovf ? {SAT_BYTE, SAT_BYTE}
                         : {sum[PW-2:W-1], sum[PW-1], sum[W-2:0]};

      a_r4_sign_copy: assert property (@(posedge clk) disable iff (!rst_n)
        hi_data[W-1] == lo_data[W-1]);
      a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (load_r && a_q == MOST_NEG && b_q == MOST_NEG) |=>
          (hi_data == SAT_BYTE && lo_data == SAT_BYTE));
      a_r6_round_either: assert property (@(posedge clk) disable iff (!rst_n)
        (load_a || load_b) |=> rnd_q == $past(round_in));
    end else begin : g_unsigned
      logic [PW-1:0] sum;
      assign sum   = {{W{1'b0}}, a_q} * {{W{1'b0}}, b_q}
                   + {{W{1'b0}}, rnd_q, {(W-1){1'b0}}};
      assign res_d = sum;

      a_r6_round_a_only: assert property (@(posedge clk) disable iff (!rst_n)
        !load_a |=> $stable(rnd_q));
    end
  endgenerate

  assign hi_data  = res_q[PW-1:W];
  assign lo_data  = res_q[W-1:0];
  assign hi_valid = ~oe_hi_n;
  assign lo_valid = ~oe_lo_n;
  assign prod_hi  = oe_hi_n ? {W{1'bz}} : hi_data;
  assign prod_lo  = oe_lo_n ? {W{1'bz}} : lo_data;

  a_r1_a_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_a |=> $stable(a_q));
  a_r1_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_b |=> $stable(b_q));
  a_r2_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_r |=> ($stable(hi_data) && $stable(lo_data)));
  a_r7_hi_lane: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_hi_n |-> prod_hi == hi_data);
  a_r7_lo_lane: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_lo_n |-> prod_lo == lo_data);
endmodule

// File: tb/test_rnd_mult8.sv
module test_rnd_mult8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_a = 0, load_b = 0, load_r = 0, round_in = 0;
  logic [7:0] a_in = 0, b_in = 0;
  logic oe_hi_n = 0, oe_lo_n = 0;
  logic [7:0] s_phi, s_plo, s_hd, s_ld, u_phi, u_plo, u_hd, u_ld;
  logic s_hv, s_lv, u_hv, u_lv;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0]  ma = 0, mb = 0;
  bit          mrs = 0, mru = 0, msat = 0;
  logic [15:0] ms = 0, mu = 0;

  always #10 clk = ~clk;

  rnd_mult8 #(.W(8), .SIGNED_MODE(1'b1)) i_rnd_mult8 (
    .clk(clk), .rst_n(rst_n), .load_a(load_a), .load_b(load_b), .load_r(load_r),
    .round_in(round_in), .a_in(a_in), .b_in(b_in), .oe_hi_n(oe_hi_n), .oe_lo_n(oe_lo_n),
    .prod_hi(s_phi), .prod_lo(s_plo), .hi_valid(s_hv), .lo_valid(s_lv),
    .hi_data(s_hd), .lo_data(s_ld));

  rnd_mult8 #(.W(8), .SIGNED_MODE(1'b0)) i_rnd_mult8_u (
    .clk(clk), .rst_n(rst_n), .load_a(load_a), .load_b(load_b), .load_r(load_r),
    .round_in(round_in), .a_in(a_in), .b_in(b_in), .oe_hi_n(oe_hi_n), .oe_lo_n(oe_lo_n),
    .prod_hi(u_phi), .prod_lo(u_plo), .hi_valid(u_hv), .lo_valid(u_lv),
    .hi_data(u_hd), .lo_data(u_ld));

  function automatic logic [15:0] exp_s(logic [7:0] a, logic [7:0] b, bit r);
    int p;
    if (a == 8'h80 && b == 8'h80) return 16'h7F7F;
    p = $signed(a) * $signed(b) + (r ? 64 : 0);
    return {p[14:7], p[15], p[6:0]};
  endfunction

  function automatic logic [15:0] exp_u(logic [7:0] a, logic [7:0] b, bit r);
    int p;
    p = int'(a) * int'(b) + (r ? 128 : 0);
    return p[15:0];
  endfunction

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cyc(bit la, bit lb, bit lr, logic [7:0] a, logic [7:0] b, bit r,
                     string ts, string tu);
    @(negedge clk);
    load_a = la; load_b = lb; load_r = lr; a_in = a; b_in = b; round_in = r;
    @(posedge clk);
    if (lr) begin
      ms = exp_s(ma, mb, mrs);
      mu = exp_u(ma, mb, mru);
      msat = (ma == 8'h80 && mb == 8'h80);
    end
    if (la) ma = a;
    if (lb) mb = b;
    if (la || lb) mrs = r;
    if (la) mru = r;
    #2;
    chk(msat ? "R5" : ts, {s_hd, s_ld}, ms);
    chk(tu, {u_hd, u_ld}, mu);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20260));
    repeat (3) @(posedge clk);
    #2;
    chk("R8 signed reset", {s_hd, s_ld}, 16'h0000);
    chk("R8 unsigned reset", {u_hd, u_ld}, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    cyc(0, 0, 1, 0, 0, 0, "R8", "R8");

    // R1 / R2: independent operand loads, result hold, old operand used
    cyc(1, 1, 0, 8'd5, 8'd7, 0, "R2", "R2");
    cyc(0, 0, 1, 0, 0, 0, "R2", "R2");
    cyc(1, 0, 0, 8'd9, 8'd99, 0, "R2", "R2");
    cyc(0, 0, 1, 0, 0, 0, "R1", "R1");
    cyc(0, 1, 1, 0, 8'hF3, 0, "R1", "R1");
    cyc(0, 0, 1, 0, 0, 0, "R1", "R1");

    // R6: round sent with B strobe only
    cyc(1, 1, 0, 8'd3, 8'd5, 0, "R6", "R6");
    cyc(0, 1, 0, 0, 8'd5, 1, "R6", "R6");
    cyc(0, 0, 1, 0, 0, 0, "R6", "R6");
    chk("R6 signed round via B", {s_hd, s_ld}, exp_s(8'd3, 8'd5, 1));
    chk("R6 unsigned ignores B", {u_hd, u_ld}, exp_u(8'd3, 8'd5, 0));
    cyc(1, 0, 1, 8'd3, 0, 1, "R6", "R6");
    cyc(0, 0, 1, 0, 0, 0, "R6", "R6");

    // R5: saturation with round off and on
    cyc(1, 1, 0, 8'h80, 8'h80, 0, "R5", "R3");
    cyc(0, 0, 1, 0, 0, 0, "R5", "R3");
    chk("R5 no round", {s_hd, s_ld}, 16'h7F7F);
    cyc(1, 1, 1, 8'h80, 8'h80, 1, "R5", "R3");
    cyc(0, 0, 1, 0, 0, 0, "R5", "R3");
    chk("R5 with round", {s_hd, s_ld}, 16'h7F7F);

    // R7: lane enables
    @(negedge clk); oe_hi_n = 1; oe_lo_n = 0; #1;
    chk("R7 hi disabled valid", {15'd0, s_hv}, 16'd0);
    chk("R7 lo enabled valid", {15'd0, s_lv}, 16'd1);
    chk("R7 lo lane drives", {8'd0, s_plo}, {8'd0, s_ld});
    oe_hi_n = 0; oe_lo_n = 1; #1;
    chk("R7 hi enabled valid", {15'd0, u_hv}, 16'd1);
    chk("R7 lo disabled valid", {15'd0, u_lv}, 16'd0);
    chk("R7 hi lane drives", {8'd0, u_phi}, {8'd0, u_hd});
    oe_lo_n = 0;

    // Random strobes
    for (int i = 0; i < 3000; i++)
      cyc($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
          8'($urandom), 8'($urandom), $urandom_range(0, 1), "R2", "R2");

    // Exhaustive sweeps, round off and on
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        for (int r = 0; r < 2; r++)
          cyc(1, 1, 1, 8'(a), 8'(b), r[0], "R4", "R3");
    cyc(0, 0, 1, 0, 0, 0, "R4", "R3");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule